// File: doc/BRIEF.md
# SMBus Backlight Register Slave

This block lets a host on a two-wire SMBus read and write the byte-wide control registers of a backlight controller. It oversamples SCL and SDA with the core clock and pulls SDA low through an open-drain enable. It recognises the single-register write and read transactions. A write carries the device address, a register index and one data byte. A read sends the device address and index, then uses a repeated START to resend the address with the read bit set, and the slave returns one byte.

Five registers are held inside the block, and their contents drive output ports for the brightness, control, configuration and channel-enable logic downstream. Two more registers are read-only: fault/status and identification. Their values come from input ports. Every bit that has no function is stored as zero. Indices with no register behind them are still acknowledged, but they hold nothing.

Top module: `smbus_bl_regs`

## Requirements
- R1: The slave acknowledges only the address bytes 0x58 (write) and 0x59 (read), where bit 0 is the R/W bit. Any other address gets no ACK, and the rest of that transaction is ignored until the next START.
- R2: In a write transaction (address 0x58, index, data), the slave ACKs all three bytes and stores the data into the register at that index. Writable indices are 0x00 (PWM brightness), 0x01 (device control), 0x07 (DC brightness), 0x08 (configuration) and 0x09 (channel enable).
- R3: In a read transaction (0x58, index, repeated START, 0x59), the slave drives the selected register MSB first. It releases SDA for the ninth clock, where the master gives ACK or NACK.
- R4: After reset, PWM brightness and channel enable are 0xFF, and device control, DC brightness and configuration are 0x00. SDA is not driven.
- R5: Index 0x02 reads {2'b00, status[5:0]}: fault in bit 0, thermal shutdown in bit 1, over-current in bit 2, backlight status in bit 3, one-channel shutdown in bit 4 and two-channel shutdown in bit 5. Index 0x03 reads the 8-bit identification input.
- R6: Writes to indices 0x02 and 0x03 are ACKed and discarded. Every writable register keeps its value.
- R7: In device control and configuration, only bits 2:0 are stored. Bits 7:3 always read 0.
- R8: An index outside the seven valid ones is ACKed. Writes to it change nothing, and reads from it return 0x00.
- R9: A START or STOP in the middle of a byte aborts the transaction, so no register is written. SDA is released after any START or STOP.
- R10: The slave changes its SDA drive only while the synchronised SCL is low.
- R11: The register outputs change only in the cycle after a completed write data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| stat_i | input | 6 | Fault/status flags, bit 0 to bit 5 |
| id_i | input | 8 | Identification byte |
| pwm_brt_o | output | 8 | PWM brightness register |
| dev_ctl_o | output | 8 | Device control register (bits 2:0 live) |
| dc_brt_o | output | 8 | DC brightness register |
| cfg_o | output | 8 | Configuration register (bits 2:0 live) |
| chan_en_o | output | 8 | Per-channel enable register, CH7..CH0 |

## Verification
A table of write-then-read pairs covers every valid index plus two unused ones. Each pair with a fully populated writable register checks storage and readback. Pairs with masked registers check that the reserved bits are dropped. Pairs with read-only indices check that writes are discarded and that readback follows the inputs, and pairs with unused indices check the read-as-zero path. Further directed transactions use a foreign address, a data byte cut short by a repeated START, and a change of the status inputs between reads. Together these separate a slave that matches the wrong address, commits partial bytes or misplaces the status bits from a correct one.

// File: rtl/smbus_bl_pkg.sv
package smbus_bl_pkg;
    localparam int DW  = 8;
    localparam int NWR = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA, ST_ACK, ST_SKIP
    } bus_st_e;

    // writable slots: index, live-bit mask, reset value
    localparam logic [DW-1:0] WR_IDX  [NWR] = '{8'h00, 8'h01, 8'h07, 8'h08, 8'h09};
    localparam logic [DW-1:0] WR_MASK [NWR] = '{8'hFF, 8'h07, 8'hFF, 8'h07, 8'hFF};
    localparam logic [DW-1:0] WR_RST  [NWR] = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF};

    localparam logic [DW-1:0] IDX_STAT = 8'h02;
    localparam logic [DW-1:0] IDX_ID   = 8'h03;
    localparam int STAT_W = 6;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl   = {q.scl[STAGES-2:0], scl_i};
        d.sda   = {q.sda[STAGES-2:0], sda_i};
        d.scl_p = q.scl[STAGES-1];
        d.sda_p = q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_o    = q.scl[STAGES-1];
    assign sda_o    = q.sda[STAGES-1];
    assign scl_rise = scl_o & ~q.scl_p;
    assign scl_fall = ~scl_o & q.scl_p;
    assign start_p  = scl_o & q.scl_p & q.sda_p & ~sda_o;
    assign stop_p   = scl_o & q.scl_p & ~q.sda_p & sda_o;
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
    import smbus_bl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h2C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_p,
    input  logic          stop_p,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic [DW-1:0] ptr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        bus_st_e       st;
        bus_st_e       after;
        logic [CW-1:0] cnt;
        logic          full;
        logic [DW-1:0] sh;
        logic [DW-1:0] ptr;
        logic          oe;
        logic          we;
    } fsm_t;

    fsm_t q, d;
    logic [DW-1:0] byte_in;

    assign byte_in = {q.sh[DW-2:0], sda_s};

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_p) begin
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.full = 1'b0;
        end else if (start_p) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.full = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && !q.full) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST) begin
                            d.full = 1'b1;
                            if (q.st == ST_ADDR) begin
                                if (byte_in[DW-1:1] == DEV_ADDR7) begin
                                    d.after = byte_in[0] ? ST_RDATA : ST_CMD;
                                end else begin
                                    d.st   = ST_SKIP;
                                    d.full = 1'b0;
                                end
                            end else if (q.st == ST_CMD) begin
                                d.ptr   = byte_in;
                                d.after = ST_WDATA;
                            end else begin
                                d.we    = 1'b1;
                                d.after = ST_SKIP;
                            end
                        end
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.oe   = 1'b1;
                        d.st   = ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.st  = q.after;
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        if (q.after == ST_RDATA) begin
                            d.sh = rd_data;
                            d.oe = ~rd_data[DW-1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.oe = 1'b0;
                            d.st = ST_SKIP;
                        end else begin
                            d.sh  = {q.sh[DW-2:0], 1'b0};
                            d.oe  = ~q.sh[DW-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.after <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign ptr     = q.ptr;
    assign wr_en   = q.we;
    assign wr_data = q.sh;
endmodule

// File: rtl/bl_regfile.sv
module bl_regfile
    import smbus_bl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [DW-1:0]           idx,
    input  logic [DW-1:0]           wdata,
    input  logic [STAT_W-1:0]       stat_i,
    input  logic [DW-1:0]           id_i,
    output logic [DW-1:0]           rdata,
    output logic [NWR-1:0][DW-1:0]  regs
);
    logic [NWR-1:0][DW-1:0] regs_d, regs_q;

    for (genvar i = 0; i < NWR; i++) begin : g_slot
        always_comb begin
            regs_d[i] = regs_q[i];
            if (wr_en && idx == WR_IDX[i]) regs_d[i] = wdata & WR_MASK[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWR; i++) regs_q[i] <= WR_RST[i];
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NWR; i++) begin
            if (idx == WR_IDX[i]) rdata = regs_q[i];
        end
        if (idx == IDX_STAT) rdata = {{(DW-STAT_W){1'b0}}, stat_i};
        if (idx == IDX_ID)   rdata = id_i;
    end

    assign regs = regs_q;
endmodule

// File: rtl/smbus_bl_regs.sv
module smbus_bl_regs
    import smbus_bl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR7   = 7'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [DW-1:0]     id_i,
    output logic [DW-1:0]     pwm_brt_o,
    output logic [DW-1:0]     dev_ctl_o,
    output logic [DW-1:0]     dc_brt_o,
    output logic [DW-1:0]     cfg_o,
    output logic [DW-1:0]     chan_en_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic wr_en;
    logic [DW-1:0] ptr, wr_data, rd_data;
    logic [NWR-1:0][DW-1:0] regs;

    bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    smb_slave_fsm #(.DEV_ADDR7(DEV_ADDR7)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
        .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    bl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(ptr), .wdata(wr_data),
        .stat_i(stat_i), .id_i(id_i), .rdata(rd_data), .regs(regs)
    );

    assign pwm_brt_o = regs[0];
    assign dev_ctl_o = regs[1];
    assign dc_brt_o  = regs[2];
    assign cfg_o     = regs[3];
    assign chan_en_o = regs[4];
endmodule

// File: rtl/smbus_bl_chk.sv
module smbus_bl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_p,
    input logic       stop_p,
    input logic       wr_en,
    input logic       sda_oe,
    input logic [7:0] pwm_brt_o,
    input logic [7:0] dev_ctl_o,
    input logic [7:0] dc_brt_o,
    input logic [7:0] cfg_o,
    input logic [7:0] chan_en_o
);
    assert_release_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p || stop_p) |=> !sda_oe);

    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_p || stop_p)) |-> !scl_s);

    assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable({pwm_brt_o, dev_ctl_o, dc_brt_o, cfg_o, chan_en_o}));

    assert_reset_values_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pwm_brt_o == 8'hFF && chan_en_o == 8'hFF && dev_ctl_o == 8'h00
                           && dc_brt_o == 8'h00 && cfg_o == 8'h00 && !sda_oe));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ctl_o[7:3] == 5'd0 && cfg_o[7:3] == 5'd0));
endmodule

bind smbus_bl_regs smbus_bl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_p(start_p), .stop_p(stop_p),
    .wr_en(wr_en), .sda_oe(sda_oe), .pwm_brt_o(pwm_brt_o), .dev_ctl_o(dev_ctl_o),
    .dc_brt_o(dc_brt_o), .cfg_o(cfg_o), .chan_en_o(chan_en_o)
);

// File: tb/smbus_bl_regs_test.sv
module smbus_bl_regs_test;
    localparam int CLK_P = 10;
    localparam int QTR   = 8;
    localparam int NVEC  = 9;
    // {index, write data, expected readback}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'hA5, 8'hA5}, {8'h01, 8'hFF, 8'h07}, {8'h07, 8'h3C, 8'h3C},
        {8'h08, 8'hF9, 8'h01}, {8'h09, 8'h5A, 8'h5A}, {8'h02, 8'hFF, 8'h2B},
        {8'h03, 8'h00, 8'hC8}, {8'h05, 8'h77, 8'h00}, {8'h0A, 8'h11, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, line;
    logic [5:0] stat = 6'h2B;
    logic [7:0] id = 8'hC8;
    logic [7:0] pwm, devc, dcb, cfg, chen;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    assign line = sda_m & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    smbus_bl_regs uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe(sda_oe),
        .stat_i(stat), .id_i(id), .pwm_brt_o(pwm), .dev_ctl_o(devc),
        .dc_brt_o(dcb), .cfg_o(cfg), .chan_en_o(chen)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic b_start();
        sda_m = 1'b1; scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic b_rstart();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic b_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw();
            scl_m = 1'b1; qw();
            scl_m = 1'b0;
        end
        qw();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        ack = ~line;
        scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic ninth);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            qw();
            scl_m = 1'b1; qw();
            b = {b[6:0], line};
            scl_m = 1'b0;
        end
        qw();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        ninth = line;
        scl_m = 1'b0; qw();
    endtask

    task automatic wr_txn(input logic [7:0] addr, input logic [7:0] idx, input logic [7:0] dat,
                          output logic [2:0] acks);
        logic a;
        b_start();
        send_byte(addr, a); acks[2] = a;
        send_byte(idx, a);  acks[1] = a;
        send_byte(dat, a);  acks[0] = a;
        b_stop();
    endtask

    task automatic rd_txn(input logic [7:0] idx, output logic [7:0] dat,
                          output logic [2:0] acks, output logic ninth);
        logic a;
        b_start();
        send_byte(8'h58, a); acks[2] = a;
        send_byte(idx, a);   acks[1] = a;
        b_rstart();
        send_byte(8'h59, a); acks[0] = a;
        recv_byte(dat, ninth);
        b_stop();
    endtask

    function automatic string tag_of(input logic [7:0] idx);
        if (idx == 8'h02 || idx == 8'h03) return "R6";
        if (idx == 8'h01 || idx == 8'h08) return "R7";
        if (idx == 8'h00 || idx == 8'h07 || idx == 8'h09) return "R2";
        return "R8";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] rd;
        logic ninth;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 reset state
        chk("R4 pwm reset", pwm, 8'hFF);
        chk("R4 chan reset", chen, 8'hFF);
        chk("R4 devctl reset", devc, 8'h00);
        chk("R4 dc reset", dcb, 8'h00);
        chk("R4 cfg reset", cfg, 8'h00);
        chk("R4 sda idle", {7'd0, sda_oe}, 8'h00);

        // R1 foreign address: no ACK, no write
        wr_txn(8'h5A, 8'h00, 8'h12, acks);
        chk("R1 foreign addr nack", {5'd0, acks}, 8'h00);
        chk("R1 foreign addr no write", pwm, 8'hFF);

        // table of write/readback pairs
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] vi, vw, ve;
            string t;
            {vi, vw, ve} = VEC[v];
            t = tag_of(vi);
            wr_txn(8'h58, vi, vw, acks);
            chk({t, " write acks"}, {5'd0, acks}, 8'h07);
            rd_txn(vi, rd, acks, ninth);
            chk({"R1 R3 read acks ", t}, {5'd0, acks}, 8'h07);
            chk({t, " readback"}, rd, ve);
            chk("R3 ninth clock released", {7'd0, ninth}, 8'h01);
        end

        // R2 / R7 / R6 / R8 at the output ports
        chk("R2 pwm out", pwm, 8'hA5);
        chk("R7 devctl out", devc, 8'h07);
        chk("R2 dc out", dcb, 8'h3C);
        chk("R7 cfg out", cfg, 8'h01);
        chk("R2 chan out", chen, 8'h5A);

        // R5 status follows inputs, bit positions
        stat = 6'h14;
        rd_txn(8'h02, rd, acks, ninth);
        chk("R5 status bits 2 and 4", rd, 8'h14);
        stat = 6'h01;
        rd_txn(8'h02, rd, acks, ninth);
        chk("R5 fault bit 0", rd, 8'h01);
        id = 8'h3E;
        rd_txn(8'h03, rd, acks, ninth);
        chk("R5 id input", rd, 8'h3E);

        // R9 abort mid data byte via repeated START then STOP
        begin
            logic a;
            b_start();
            send_byte(8'h58, a);
            send_byte(8'h00, a);
            for (int i = 7; i >= 4; i--) begin
                sda_m = 1'b0; qw();
                scl_m = 1'b1; qw();
                scl_m = 1'b0;
            end
            qw();
            b_rstart();
            b_stop();
        end
        chk("R9 aborted byte not written", pwm, 8'hA5);
        chk("R9 sda released after stop", {7'd0, sda_oe}, 8'h00);

        // R11 reads leave outputs alone
        rd_txn(8'h00, rd, acks, ninth);
        chk("R11 pwm after read", pwm, 8'hA5);
        chk("R3 pwm readback", rd, 8'hA5);

        // R1 foreign address after valid traffic
        wr_txn(8'h5E, 8'h09, 8'h00, acks);
        chk("R1 foreign addr keeps chan", chen, 8'h5A);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule